// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the byte-level protocol engine of a 2048 x 8 two-wire serial memory. A front end, which is not part of this block, filters the clock and data pins and hands over one-cycle event pulses: start condition, stop condition, rising clock edge (with the sampled data level) and falling clock edge. From these events the engine decodes the address word and the low memory address. It acknowledges bytes by pulling the data line low through an open-drain enable. It runs single-byte and page writes, current-address, random and sequential reads. It also models the self-timed write cycle.

The memory array and a page buffer sit inside the datapath. Write data goes into the page buffer and reaches the array only when a stop condition closes the transfer. After that, a busy window of a configurable number of system clocks follows. During the window the engine ignores the bus, so a master can find out when the write has finished by sending address words until one is acknowledged. A write-protect input blocks array updates and leaves reads unaffected.

Top module: `eeprom_slave`

## Requirements
- R1: An address word whose upper four bits are 1010 is acknowledged. Bits 3..1 of a write-mode word supply address bits 10..8. Bit 0 selects the access: 1 means read and 0 means write.
- R2: An address word whose upper four bits are not 1010 gets no acknowledge, and every later bit is ignored until the next start condition.
- R3: The engine pulls the data line low during the ninth clock after the address word, after the low memory address byte and after each write data byte. The data-line enable changes only on a falling clock edge, a start condition or a stop condition.
- R4: A stop condition after one or more write data bytes begins a write cycle lasting TWR_CYCLES clocks. A stop condition right after the memory address byte loads the address counter and begins no write cycle.
- R5: While the write cycle runs, every bus event is ignored and no address word is acknowledged. The first address word after the cycle ends is acknowledged.
- R6: If the protect input is high at any clock between a start condition and the stop condition that closes a write, the array is left unchanged and no write cycle begins. Reads return stored data whatever the protect level.
- R7: A random read is a write-mode address word, then the low address byte, then a repeated start and a read-mode word. The first data byte comes from the address just loaded.
- R8: When the master acknowledges a read byte, the engine sends the byte at the next address, and the address wraps from 0x7FF to 0x000. A master no-acknowledge ends the read, and the data line stays released until the next start.
- R9: Each write data byte goes to the next location within its 16-byte page. The low four address bits wrap inside the page, and a later byte overwrites an earlier one at the same location.
- R10: A read-mode word with no address phase reads from the address counter and ignores its own bits 3..1. After a page write, the counter points one past the last byte written, wrapped within the page.
- R11: After reset every array byte reads 0xFF, the address counter is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEv | input | 1 | One-cycle pulse: start or repeated start detected |
| stopEv | input | 1 | One-cycle pulse: stop condition detected |
| sclRise | input | 1 | One-cycle pulse: serial clock rose, sdaIn valid |
| sclFall | input | 1 | One-cycle pulse: serial clock fell |
| sdaIn | input | 1 | Filtered data line level |
| wp | input | 1 | Write protect, high blocks array writes |
| sdaOe | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The assertions assume that the event inputs are mutually exclusive pulses. At most one of start, stop, rising edge and falling edge may be high in any cycle, and rising and falling edges alternate, beginning with a rising edge after each start. The stimulus tasks raise exactly one event for one cycle, with an idle cycle after it, and always complete a rise before the matching fall. The data level is set before the rising edge. The bench samples the enable only after the falling-edge pulse has been registered.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } phase_t;

  // strobes from control to datapath, at most a few high per cycle
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic setHi;     // latch high address bits from the address word
    logic loadAddr;  // load full address counter after low address byte
    logic wrBuf;     // store received byte in the page buffer
    logic loadTx;    // fetch array byte into transmit register
    logic shiftTx;   // advance transmit register by one bit
    logic clrBuf;    // discard page buffer contents
    logic commit;    // copy page buffer into the array
  } strobe_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eeprom_dpath.sv
module eeprom_dpath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sdaIn,
  input  strobe_t stb,
  output logic [7:0] rxNext,
  output logic    memMsb,
  output logic    txNext
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PSIZE = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [7:0]        shiftQ;
  logic [7:0]        txQ;
  logic [HI_W-1:0]   hiQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PSIZE];
  logic [PSIZE-1:0]  validQ;

  assign rxNext = {shiftQ[6:0], sdaIn};
  assign memMsb = mem[addrQ][7];
  assign txNext = txQ[6];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      txQ    <= '0;
      hiQ    <= '0;
      addrQ  <= '0;
    end else begin
      if (stb.shiftIn) shiftQ <= rxNext;
      if (stb.setHi) hiQ <= rxNext[HI_W:1];
      if (stb.loadAddr) begin
        addrQ <= {hiQ, rxNext};
      end else if (stb.wrBuf) begin
        addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + 1'b1;
      end else if (stb.loadTx) begin
        addrQ <= addrQ + 1'b1;
      end
      if (stb.loadTx) txQ <= mem[addrQ];
      else if (stb.shiftTx) txQ <= {txQ[6:0], 1'b0};
    end
  end

  // one slot per page location
  for (genvar slot = 0; slot < PSIZE; slot++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageBuf[slot] <= '0;
        validQ[slot]  <= 1'b0;
      end else if (stb.clrBuf) begin
        validQ[slot] <= 1'b0;
      end else if (stb.wrBuf && addrQ[PAGE_W-1:0] == PAGE_W'(slot)) begin
        pageBuf[slot] <= rxNext;
        validQ[slot]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.commit) begin
      for (int i = 0; i < PSIZE; i++) begin
        if (validQ[i])
          mem[{addrQ[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  logic [BASE_W-1:0] unusedBase;
  assign unusedBase = addrQ[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int TWR_CYCLES = 500000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startEv,
  input  logic    stopEv,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    sdaIn,
  input  logic    wp,
  input  logic [7:0] rxNext,
  input  logic    memMsb,
  input  logic    txNext,
  output strobe_t stb,
  output logic    sdaOe,
  output logic    busy
);

  localparam int CW = $clog2(TWR_CYCLES + 1);

  logic [CW-1:0] busyCnt;
  phase_t        state, nxt;
  logic [3:0]    cnt;
  logic          ackPend, loadPend, hasData, wpSeen, oeQ;

  assign busy  = (busyCnt != '0);
  assign sdaOe = oeQ;

  logic devOk, rxPhase, lastBit, wrGo, live, txWin;
  assign devOk   = (rxNext[7:4] == DEV_CODE);
  assign rxPhase = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
  assign live    = !busy && !startEv && !stopEv;
  assign lastBit = live && sclRise && rxPhase && (cnt == 4'd7);
  assign wrGo    = !busy && stopEv && (state == ST_WDATA) && hasData && !(wpSeen || wp);
  assign txWin   = (state == ST_RDATA) && (cnt >= 4'd1) && (cnt <= 4'd7);

  always_comb begin
    stb          = '0;
    stb.shiftIn  = live && sclRise && rxPhase && (cnt < 4'd8);
    stb.setHi    = lastBit && (state == ST_DEV) && devOk && !rxNext[0];
    stb.loadAddr = lastBit && (state == ST_ADDR);
    stb.wrBuf    = lastBit && (state == ST_WDATA);
    stb.loadTx   = live && sclFall && !ackPend && loadPend;
    stb.shiftTx  = live && sclFall && !ackPend && !loadPend && txWin;
    stb.clrBuf   = !busy && startEv;
    stb.commit   = wrGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= '0;
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      cnt      <= '0;
      ackPend  <= 1'b0;
      loadPend <= 1'b0;
      hasData  <= 1'b0;
      wpSeen   <= 1'b0;
      oeQ      <= 1'b0;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
      state   <= ST_IDLE;
      oeQ     <= 1'b0;
    end else if (startEv) begin
      state    <= ST_DEV;
      cnt      <= '0;
      ackPend  <= 1'b0;
      loadPend <= 1'b0;
      hasData  <= 1'b0;
      wpSeen   <= wp;
      oeQ      <= 1'b0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      ackPend  <= 1'b0;
      loadPend <= 1'b0;
      oeQ      <= 1'b0;
      if (wrGo) busyCnt <= CW'(TWR_CYCLES);
    end else begin
      if (wp) wpSeen <= 1'b1;
      if (sclRise) begin
        if (rxPhase) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              unique case (state)
                ST_DEV: begin
                  if (devOk) begin
                    ackPend <= 1'b1;
                    nxt     <= rxNext[0] ? ST_RDATA : ST_ADDR;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_ADDR: begin
                  ackPend <= 1'b1;
                  nxt     <= ST_WDATA;
                end
                default: begin
                  ackPend <= 1'b1;
                  hasData <= 1'b1;
                  nxt     <= ST_WDATA;
                end
              endcase
            end
          end else begin
            cnt   <= '0;
            state <= nxt;
            if (nxt == ST_RDATA) loadPend <= 1'b1;
          end
        end else if (state == ST_RDATA) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!sdaIn) loadPend <= 1'b1;
            else        state <= ST_IDLE;
          end
        end
      end
      if (sclFall) begin
        if (ackPend) begin
          oeQ     <= 1'b1;
          ackPend <= 1'b0;
        end else if (loadPend) begin
          oeQ      <= !memMsb;
          loadPend <= 1'b0;
        end else if (txWin) begin
          oeQ <= !txNext;
        end else begin
          oeQ <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int TWR_CYCLES = 500000,
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic startEv,
  input  logic stopEv,
  input  logic sclRise,
  input  logic sclFall,
  input  logic sdaIn,
  input  logic wp,
  output logic sdaOe
);

  strobe_t    stb;
  logic [7:0] rxNext;
  logic       memMsb, txNext, busy;

  eeprom_ctrl #(.TWR_CYCLES(TWR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .wp(wp),
    .rxNext(rxNext), .memMsb(memMsb), .txNext(txNext),
    .stb(stb), .sdaOe(sdaOe), .busy(busy)
  );

  eeprom_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .stb(stb),
    .rxNext(rxNext), .memMsb(memMsb), .txNext(txNext)
  );

endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
  input logic clk,
  input logic rstN,
  input logic startEv,
  input logic stopEv,
  input logic sclFall,
  input logic wp,
  input logic sdaOe,
  input logic busy
);

  // R5: bus stays released for the whole write cycle
  assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R3: enable moves only on a falling clock, start or stop
  assert_oe_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startEv && !stopEv) |=> $stable(sdaOe));

  // R8: a stop always leaves the line released
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R2: a start releases the line before the address word
  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe);

  // R4: a write cycle only begins on a stop
  assert_cycle_on_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));

  // R6: protect high at the closing stop never begins a cycle
  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wp));

endmodule

bind eeprom_slave eeprom_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
  .sclFall(sclFall), .wp(wp), .sdaOe(sdaOe), .busy(busy)
);

// File: tb/eeprom_slave_tb.sv
module eeprom_slave_tb;

  localparam int TWR = 200;
  localparam int NVEC = 6;
  // {address[10:0], data[7:0], protect}
  localparam logic [19:0] VEC [NVEC] = '{
    {11'h000, 8'h5A, 1'b0},
    {11'h3C1, 8'hA5, 1'b0},
    {11'h7FF, 8'h81, 1'b0},
    {11'h255, 8'h33, 1'b1},
    {11'h4F0, 8'hC3, 1'b0},
    {11'h012, 8'h7E, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic startEv = 1'b0, stopEv = 1'b0, sclRise = 1'b0, sclFall = 1'b0;
  logic sdaIn = 1'b1, wp = 1'b0;
  logic sdaOe;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eeprom_slave #(.TWR_CYCLES(TWR)) u_dut (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .wp(wp),
    .sdaOe(sdaOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rise();  @(negedge clk) sclRise = 1'b1; @(negedge clk) sclRise = 1'b0; endtask
  task automatic fall();  @(negedge clk) sclFall = 1'b1; @(negedge clk) sclFall = 1'b0; endtask
  task automatic startC(); @(negedge clk) startEv = 1'b1; @(negedge clk) startEv = 1'b0; endtask
  task automatic stopC();  @(negedge clk) stopEv  = 1'b1; @(negedge clk) stopEv  = 1'b0; endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaIn = b[i]; rise(); fall();
    end
    ack = sdaOe;
    sdaIn = 1'b1; rise(); fall();
  endtask

  task automatic readByte(input logic nack, output logic [7:0] b);
    sdaIn = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      b[i] = ~sdaOe; rise(); fall();
    end
    sdaIn = nack; rise(); fall();
    sdaIn = 1'b1;
  endtask

  function automatic logic [7:0] devW(input logic [10:0] a);
    return {4'hA, a[10:8], 1'b0};
  endfunction

  task automatic waitReady(output int polls);
    logic k;
    polls = 0;
    do begin
      startC(); sendByte(8'hA0, k); polls++;
    end while (!k && polls < 100);
    stopC();
  endtask

  task automatic rdCheck(input logic [10:0] a, input logic [7:0] exp, input string req);
    logic k;
    logic [7:0] b;
    startC(); sendByte(devW(a), k); sendByte(a[7:0], k);
    startC(); sendByte(8'hA1, k); readByte(1'b1, b); stopC();
    check(req, b, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic k1, k2, k3;
    logic [7:0] b, b2;
    int polls;
    logic [7:0] model [16];

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 line released after reset", sdaOe, 1'b0);
    rdCheck(11'h7AB, 8'hFF, "R11 erased array");

    // R2: foreign device code ignored
    startC(); sendByte(8'hB0, k1); sendByte(8'hA0, k2); stopC();
    check("R2 foreign code no ack", {k1, k2}, 2'b00);

    // vector table: write, poll, read back (R1 R3 R5 R6 R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] a;
      logic [7:0] d;
      logic p;
      a = VEC[v][19:9]; d = VEC[v][8:1]; p = VEC[v][0];
      wp = p;
      startC(); sendByte(devW(a), k1); sendByte(a[7:0], k2); sendByte(d, k3); stopC();
      wp = 1'b0;
      check("R1 R3 write acks", {k1, k2, k3}, 3'b111);
      waitReady(polls);
      if (p) check("R6 no cycle when protected", polls, 1);
      else   check("R5 poll nacked while busy", polls > 1, 1'b1);
      rdCheck(a, p ? 8'hFF : d, "R7 random read");
    end

    // R8: sequential read wraps 7FF -> 000, nack ends
    startC(); sendByte(devW(11'h7FF), k1); sendByte(8'hFF, k1);
    startC(); sendByte(8'hA1, k1); readByte(1'b0, b); readByte(1'b1, b2);
    check("R8 last address", b, 8'h81);
    check("R8 wrap to zero", b2, 8'h5A);
    rise(); fall(); rise(); fall();
    check("R8 released after nack", sdaOe, 1'b0);
    stopC();

    // R4 + R10: address-only write, then current read with foreign high bits
    startC(); sendByte(devW(11'h3C1), k1); sendByte(8'hC1, k1); stopC();
    startC(); sendByte(8'hAF, k2); readByte(1'b1, b); stopC();
    check("R4 no cycle after address only", k2, 1'b1);
    check("R10 current read ignores word bits", b, 8'hA5);

    // R9: page write with in-page wrap and overwrite
    for (int j = 0; j < 16; j++) model[j] = 8'hFF;
    startC(); sendByte(devW(11'h125), k1); sendByte(8'h25, k1);
    for (int i = 0; i < 18; i++) begin
      sendByte(8'h40 + 8'(i), k1);
      model[(5 + i) % 16] = 8'h40 + 8'(i);
    end
    stopC();
    waitReady(polls);
    startC(); sendByte(8'hA1, k1); readByte(1'b1, b); stopC();
    check("R10 counter after page write", b, model[7]);
    startC(); sendByte(devW(11'h120), k1); sendByte(8'h20, k1);
    startC(); sendByte(8'hA1, k1);
    for (int j = 0; j < 16; j++) begin
      readByte(j == 15, b);
      check("R9 page contents", b, model[j]);
    end
    stopC();

    // R6: brief protect pulse in mid-transfer blocks the write
    startC(); sendByte(devW(11'h600), k1);
    wp = 1'b1; @(negedge clk); wp = 1'b0;
    sendByte(8'h00, k1); sendByte(8'h11, k1); stopC();
    waitReady(polls);
    check("R6 no cycle after protect pulse", polls, 1);
    rdCheck(11'h600, 8'hFF, "R6 array unchanged");

    // R6: reads unaffected by protect
    wp = 1'b1;
    rdCheck(11'h3C1, 8'hA5, "R6 read while protected");
    wp = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule